// File: doc/BRIEF.md
# Maskable Interrupt Controller with Vectoring

This block sits beside a small microcontroller core and decides when the core must leave its current program and jump to the interrupt service routine. It keeps one event flag per interrupt source, a per-source enable mask, a global enable and a second enable that gates the peripheral group only. A flag is set by its event no matter how the mask and enable bits stand, so software can always poll the flags. A request goes to the core whenever the global enable is on and at least one enabled source has its flag set.

At an instruction boundary the core lets the controller take the interrupt. The controller then clears the global enable, pushes the core's return address onto an internal last-in first-out stack and presents a one-cycle program-counter load to the fixed vector 0x0004. A return strobe from the core pops that address, presents it as the next load and sets the global enable again. Flags are cleared only by software writes. A flag left set therefore re-raises the request as soon as the global enable comes back. Working and status registers are the routine's job. Priority among sources is also left to software, which polls the flags.

Top module: `icu_top`

## Requirements
- R1: A source flag sets on the clock edge that samples its event, whatever the state of the mask, the peripheral enable and the global enable. In the flag vector, the synchronous core events use bits [2:0], the external pin uses bit 3 and the peripheral events use bits [7:4].
- R2: `irq_req` is high exactly when the global enable is set and either a core-group bit (bits [3:0]) has both flag and mask set, or the peripheral enable is set and a peripheral bit (bits [7:4]) has both flag and mask set.
- R3: A take happens when `irq_req` and `core_boundary` are high and `reti` is low at a clock edge. After that edge, `pc_load` is high for one cycle with `pc_target` = 0x0004 and the global enable reads 0. A ctrl write in the same cycle does not set the global enable.
- R4: A take pushes `ret_pc`. A `reti` pulse pops the most recent entry. After that edge, `pc_load` is high for one cycle with `pc_target` equal to the popped address, and the global enable reads 1.
- R5: A write to address 0 keeps each flag whose data bit is 1 and clears each flag whose data bit is 0. An event in the same cycle wins over the clear. Flags change in no other way.
- R6: If a flag and its mask bit are still set when `reti` restores the global enable, `irq_req` is high in the very next cycle.
- R7: A peripheral source raises `irq_req` only while the peripheral enable (ctrl bit 1) is set.
- R8: A rising edge on the asynchronous pin sets flag bit 3 on the third clock edge that samples the pin high. A pin held high sets the flag only once.
- R9: The return stack holds 8 entries. A ninth push overwrites the oldest entry without any error, so nine pops return the ninth address, then the eighth down to the second, and then the ninth again.
- R10: After reset, flags, mask, global enable and peripheral enable are 0, and `irq_req` and `pc_load` are low.
- R11: `reg_rdata` returns the flags at address 0, the mask at address 1, and {peripheral enable, global enable} in bits [1:0] at address 2. Writes to address 1 and to address 2 load those registers.
- R12: While `core_boundary` is low, a pending request is held and no load is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_evt | input | NUM_CORE | Synchronous core-group event pulses |
| pin_evt | input | NUM_PIN | Asynchronous external event pins (core group) |
| peri_evt | input | NUM_PERI | Synchronous peripheral event pulses |
| reg_addr | input | 2 | Register address: 0 flags, 1 mask, 2 ctrl |
| reg_wdata | input | NSRC | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | NSRC | Register read data for `reg_addr` |
| core_boundary | input | 1 | Core is at an instruction boundary and may be interrupted |
| ret_pc | input | PC_W | Return address pushed on a take |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_target | output | PC_W | Address to load into the program counter |

## Verification
The bench builds the block with its defaults: three synchronous core sources, one asynchronous pin, four peripheral sources, a 13-bit program counter and an 8-entry stack. With one pin, the synchronizer latency and the held-level case can be checked exactly. With four peripheral bits, the peripheral-enable gate can be checked apart from the core group. An 8-entry stack lets nine nested takes, triggered by re-enabling with a flag left set, reach the wrap-around in a few dozen cycles.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {
    RA_FLAGS = 2'd0,
    RA_MASK  = 2'd1,
    RA_CTRL  = 2'd2,
    RA_RSVD  = 2'd3
  } icu_reg_e;

  localparam int CTRL_GIE = 0;
  localparam int CTRL_PIE = 1;
endpackage

// File: rtl/icu_sync_edge.sv
module icu_sync_edge #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    logic s1_d, s2_d, prev_d;

    always_comb begin
      s1_d   = pin[g];
      s2_d   = s1_q;
      prev_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= s1_d;
        s2_q   <= s2_d;
        prev_q <= prev_d;
      end
    end

    assign rise[g] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/icu_flag_bank.sv
module icu_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_flag_i,
  input  logic         wr_mask_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_flag_i) flag_d = flag_q & wdata_i;
    flag_d = flag_d | set_i;
    mask_d = wr_mask_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/icu_ret_stack.sv
module icu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_d;
  logic [PTR_W-1:0] sp_inc, sp_dec;

  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_comb begin
    sp_d = sp_q;
    if (push_i)      sp_d = sp_inc;
    else if (pop_i)  sp_d = sp_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[sp_q] <= push_data_i;
  end

  assign top_o = mem[sp_dec];
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int NUM_CORE    = 3,
  parameter int NUM_PIN     = 1,
  parameter int NUM_PERI    = 4,
  parameter int PC_W        = 13,
  parameter int STACK_DEPTH = 8,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_CORE-1:0]                   core_evt,
  input  logic [NUM_PIN-1:0]                    pin_evt,
  input  logic [NUM_PERI-1:0]                   peri_evt,
  input  logic [1:0]                            reg_addr,
  input  logic [NUM_CORE+NUM_PIN+NUM_PERI-1:0]  reg_wdata,
  input  logic                                  reg_we,
  output logic [NUM_CORE+NUM_PIN+NUM_PERI-1:0]  reg_rdata,
  input  logic                                  core_boundary,
  input  logic [PC_W-1:0]                       ret_pc,
  input  logic                                  reti,
  output logic                                  irq_req,
  output logic                                  pc_load,
  output logic [PC_W-1:0]                       pc_target
);
  localparam int NCG  = NUM_CORE + NUM_PIN;
  localparam int NSRC = NCG + NUM_PERI;

  icu_reg_e       ra;
  logic [NUM_PIN-1:0] pin_rise;
  logic [NSRC-1:0] set_vec, flags, mask, pend;
  logic           core_hit, peri_hit, take;
  logic           wr_flag, wr_mask, wr_ctrl;
  logic           gie_q, gie_d, pie_q, pie_d;
  logic           pc_load_q, pc_load_d;
  logic [PC_W-1:0] pc_target_q, pc_target_d, stack_top;

  assign ra = icu_reg_e'(reg_addr);

  icu_sync_edge #(.N(NUM_PIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin_evt),
    .rise (pin_rise)
  );

  assign set_vec = {peri_evt, pin_rise, core_evt};
  assign wr_flag = reg_we & (ra == RA_FLAGS);
  assign wr_mask = reg_we & (ra == RA_MASK);
  assign wr_ctrl = reg_we & (ra == RA_CTRL);

  icu_flag_bank #(.N(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .wr_flag_i(wr_flag),
    .wr_mask_i(wr_mask),
    .wdata_i  (reg_wdata),
    .flags_o  (flags),
    .mask_o   (mask)
  );

  assign pend     = flags & mask;
  assign core_hit = |pend[NCG-1:0];
  assign peri_hit = |pend[NSRC-1:NCG];
  assign irq_req  = gie_q & (core_hit | (pie_q & peri_hit));
  assign take     = irq_req & core_boundary & ~reti;

  icu_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take),
    .pop_i      (reti),
    .push_data_i(ret_pc),
    .top_o      (stack_top)
  );

  always_comb begin
    gie_d = gie_q;
    if (take)         gie_d = 1'b0;
    else if (reti)    gie_d = 1'b1;
    else if (wr_ctrl) gie_d = reg_wdata[CTRL_GIE];
    pie_d       = wr_ctrl ? reg_wdata[CTRL_PIE] : pie_q;
    pc_load_d   = take | reti;
    pc_target_d = take ? VECTOR : stack_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q       <= 1'b0;
      pie_q       <= 1'b0;
      pc_load_q   <= 1'b0;
      pc_target_q <= '0;
    end else begin
      gie_q     <= gie_d;
      pie_q     <= pie_d;
      pc_load_q <= pc_load_d;
      if (pc_load_d) pc_target_q <= pc_target_d;
    end
  end

  assign pc_load   = pc_load_q;
  assign pc_target = pc_target_q;

  always_comb begin
    unique case (ra)
      RA_FLAGS: reg_rdata = flags;
      RA_MASK:  reg_rdata = mask;
      RA_CTRL:  reg_rdata = NSRC'({pie_q, gie_q});
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int NUM_CORE = 3,
  parameter int NSRC     = 8,
  parameter int NCG      = 4,
  parameter int PC_W     = 13,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CORE-1:0] core_evt,
  input logic                core_boundary,
  input logic                reti,
  input logic                irq_req,
  input logic                pc_load,
  input logic [PC_W-1:0]     pc_target,
  input logic [NSRC-1:0]     flags,
  input logic [NSRC-1:0]     mask,
  input logic                gie,
  input logic                pie
);
  localparam logic [NSRC-1:0] CORE_BITS = {{(NSRC-NCG){1'b0}}, {NCG{1'b1}}};

  a_r1_core_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_evt) |=> ((flags[NUM_CORE-1:0] & $past(core_evt)) == $past(core_evt)));

  a_r2_no_req_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  a_r3_take_vectors: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && core_boundary && !reti) |=> (pc_load && pc_target == VECTOR && !gie));

  a_r4_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> (pc_load && gie));

  a_r7_peri_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pie && ((flags & mask & CORE_BITS) == '0)) |-> !irq_req);

  a_r12_no_spurious_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_req && core_boundary) && !reti) |=> !pc_load);
endmodule

bind icu_top icu_checker #(
  .NUM_CORE(NUM_CORE),
  .NSRC    (NUM_CORE + NUM_PIN + NUM_PERI),
  .NCG     (NUM_CORE + NUM_PIN),
  .PC_W    (PC_W),
  .VECTOR  (VECTOR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_evt     (core_evt),
  .core_boundary(core_boundary),
  .reti         (reti),
  .irq_req      (irq_req),
  .pc_load      (pc_load),
  .pc_target    (pc_target),
  .flags        (flags),
  .mask         (mask),
  .gie          (gie_q),
  .pie          (pie_q)
);

// File: tb/sim_icu_top.sv
module sim_icu_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  core_evt;
  logic [0:0]  pin_evt;
  logic [3:0]  peri_evt;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic [7:0]  reg_rdata;
  logic        core_boundary;
  logic [PCW-1:0] ret_pc;
  logic        reti;
  logic        irq_req;
  logic        pc_load;
  logic [PCW-1:0] pc_target;

  int total = 0;
  int fails = 0;
  int cyc_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_top u0 (
    .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .pin_evt(pin_evt),
    .peri_evt(peri_evt), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .core_boundary(core_boundary),
    .ret_pc(ret_pc), .reti(reti), .irq_req(irq_req), .pc_load(pc_load),
    .pc_target(pc_target)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_flags, m_mask;
  bit         m_gie, m_pie, m_load;
  logic [PCW-1:0] m_tgt;
  logic [PCW-1:0] m_stk [$];
  logic [PCW-1:0] m_ring [8];
  int         m_sp;
  bit         m_s1, m_s2, m_pr;

  function automatic bit m_req();
    return m_gie && ((|(m_flags & m_mask & 8'h0F)) ||
                     (m_pie && (|(m_flags & m_mask & 8'hF0))));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_mask = '0; m_gie = 0; m_pie = 0; m_load = 0;
      m_tgt = '0; m_sp = 0; m_s1 = 0; m_s2 = 0; m_pr = 0;
    end else begin
      bit take;
      logic [7:0] nf;
      take = m_req() && core_boundary && !reti;
      nf = m_flags;
      if (reg_we && reg_addr == 2'd0) nf = nf & reg_wdata;
      nf = nf | {peri_evt, (m_s2 & ~m_pr), core_evt};
      m_pr = m_s2; m_s2 = m_s1; m_s1 = pin_evt[0];
      if (reg_we && reg_addr == 2'd1) m_mask = reg_wdata;
      if (take) begin
        m_ring[m_sp] = ret_pc; m_sp = (m_sp + 1) % 8;
        m_gie = 0; m_load = 1; m_tgt = 13'h0004;
      end else if (reti) begin
        m_sp = (m_sp + 7) % 8; m_tgt = m_ring[m_sp];
        m_gie = 1; m_load = 1;
      end else begin
        m_load = 0;
      end
      if (reg_we && reg_addr == 2'd2) begin
        m_pie = reg_wdata[1];
        if (!take && !reti) m_gie = reg_wdata[0];
      end
      m_flags = nf;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] rexp;
      check("R2 irq_req vs model", 32'(irq_req), 32'(m_req()));
      check("R3 pc_load vs model", 32'(pc_load), 32'(m_load));
      if (m_load) check("R4 pc_target vs model", 32'(pc_target), 32'(m_tgt));
      case (reg_addr)
        2'd0: rexp = m_flags;
        2'd1: rexp = m_mask;
        2'd2: rexp = {6'd0, m_pie, m_gie};
        default: rexp = 8'd0;
      endcase
      check("R11 reg_rdata vs model", 32'(reg_rdata), 32'(rexp));
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc_cnt);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; core_evt = '0; pin_evt = '0; peri_evt = '0;
    reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; core_boundary = 1'b0;
    ret_pc = '0; reti = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc();
    // R10 reset state
    check("R10 irq_req after reset", 32'(irq_req), 0);
    check("R10 pc_load after reset", 32'(pc_load), 0);
    rd(2'd0, v); check("R10 flags after reset", 32'(v), 0);
    rd(2'd1, v); check("R10 mask after reset", 32'(v), 0);
    rd(2'd2, v); check("R10 ctrl after reset", 32'(v), 0);

    // R1 flags latch with everything disabled
    core_evt = 3'b010; peri_evt = 4'b0100;
    cyc();
    core_evt = '0; peri_evt = '0;
    rd(2'd0, v); check("R1 flags set while masked", 32'(v), 32'h42);
    check("R2 no request while disabled", 32'(irq_req), 0);

    // R5 write-zero clears, write-one keeps, event beats clear
    wr(2'd0, 8'hFD);
    rd(2'd0, v); check("R5 clear bit1 only", 32'(v), 32'h40);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check("R5 write ones keeps flags", 32'(v), 32'h40);
    core_evt = 3'b001;
    wr(2'd0, 8'h00);
    core_evt = '0;
    rd(2'd0, v); check("R5 event wins over clear", 32'(v), 32'h01);
    wr(2'd0, 8'h00);

    // R11 register access
    wr(2'd1, 8'hA5);
    rd(2'd1, v); check("R11 mask readback", 32'(v), 32'hA5);
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R11 ctrl readback", 32'(v), 32'h02);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);

    // R12 held while no boundary, then R3 take
    core_evt = 3'b001;
    cyc();
    core_evt = '0;
    check("R2 request raised", 32'(irq_req), 1);
    cyc(3);
    check("R12 no load without boundary", 32'(pc_load), 0);
    check("R12 request still held", 32'(irq_req), 1);
    ret_pc = 13'h0123; core_boundary = 1'b1;
    cyc();
    core_boundary = 1'b0;
    check("R3 load strobe on take", 32'(pc_load), 1);
    check("R3 vector address", 32'(pc_target), 32'h0004);
    rd(2'd2, v); check("R3 global enable cleared", 32'(v), 32'h00);
    cyc();
    check("R3 load strobe one cycle", 32'(pc_load), 0);

    // R4 return, R6 immediate re-entry request
    reti = 1'b1;
    cyc();
    reti = 1'b0;
    check("R4 load on return", 32'(pc_load), 1);
    check("R4 popped address", 32'(pc_target), 32'h0123);
    check("R6 request again after return", 32'(irq_req), 1);
    wr(2'd0, 8'h00);
    check("R5 cleared flag drops request", 32'(irq_req), 0);

    // R7 peripheral gate
    wr(2'd1, 8'h10);
    peri_evt = 4'b0001;
    cyc();
    peri_evt = '0;
    check("R7 peripheral blocked without enable", 32'(irq_req), 0);
    wr(2'd2, 8'h03);
    check("R7 peripheral request with enable", 32'(irq_req), 1);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R8 asynchronous pin latency and held level
    pin_evt = 1'b1;
    cyc(2);
    rd(2'd0, v); check("R8 flag not yet set after two edges", 32'(v), 0);
    cyc();
    rd(2'd0, v); check("R8 flag set on third edge", 32'(v), 32'h08);
    wr(2'd0, 8'h00);
    cyc(4);
    rd(2'd0, v); check("R8 held pin sets once", 32'(v), 0);
    pin_evt = 1'b0;
    cyc(3);

    // R9 nine nested takes then nine returns
    wr(2'd1, 8'h01);
    core_evt = 3'b001;
    cyc();
    core_evt = '0;
    core_boundary = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wr(2'd2, 8'h01);
      ret_pc = 13'(32'h100 + i);
      cyc();
      check("R9 nested take vectors", 32'(pc_target), 32'h0004);
    end
    core_boundary = 1'b0;
    for (int k = 0; k < 9; k++) begin
      reti = 1'b1;
      cyc();
      check("R9 wrapped pop order", 32'(pc_target),
            (k < 8) ? 32'h108 - 32'(k) : 32'h108);
    end
    reti = 1'b0;
    wr(2'd0, 8'h00);
    cyc(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule